// File: doc/BRIEF.md
# SPI Register Host with Automatic Retry

This block sits on the controller side of an SPI link to a register-based target. The target answers each frame one transaction late. A user issues a single register read or write through a small command port. The block then sends the command frame, waits a spacing gap, and sends a follow-up read frame of the same address. The reply to the command arrives during the follow-up frame. Every frame carries a CRC-8 in its last byte.

The block sorts each follow-up reply into one of five kinds. A valid reply echoes the command header and has a correct CRC. A reply of all ones means the target clock was off. A reply of two 0xFF bytes and a 0xAA tail means the target rejected the previous frame's CRC. Two 0xFF bytes and a zero tail mean the target was not ready. Any other reply with a wrong echo or a wrong CRC is a mismatch. For every kind except a valid reply, the block waits a spacing gap and repeats the whole attempt, up to a retry limit. When the limit runs out, the command ends with an error flag that stays set. The gaps, the SPI clock rate and the retry limit are parameters counted in system clocks.

Top module: `spi_retry_host`

## Requirements
- R1: A command frame is 24 bits, sent MSB first. Byte 0 is {rw, addr[6:0]}, where rw = 1 means write. Byte 1 is the write data, or 0x00 for a read. Byte 2 is a CRC-8 over bytes 0 and 1, with polynomial 0x07, initial value 0x00 and no reflection.
- R2: The SPI bus uses mode 0. SCLK idles low while chip select (active low) is high. MOSI changes only on falling edges and MISO is sampled on rising edges. Each frame holds chip select low for exactly 24 SCLK rising edges.
- R3: Each attempt is the command frame followed by a follow-up frame. The follow-up is a read of the same address: {0, addr}, then 0x00, then the CRC. The reply received during the command frame is ignored, so a command with no faults uses exactly two frames.
- R4: A follow-up reply is valid when byte 0 equals the sent {rw, addr} and byte 2 equals the CRC of bytes 0 and 1. The command then completes with res_error = 0 and res_rdata = reply byte 1.
- R5: A follow-up reply of 0xFFFFFF, 0xFFFFAA or 0xFFFF00 repeats the attempt from its command frame and adds one to res_retries.
- R6: A follow-up reply with a wrong header echo, or with a wrong CRC, also repeats the attempt and counts one retry.
- R7: If MAX_RETRY retries have been used and the attempt still fails, the command ends with res_error = 1 and res_retries = MAX_RETRY, after 2*(MAX_RETRY+1) frames. The error flag stays set until the next command is accepted.
- R8: Within one command, chip select stays high for at least GAP_CYCLES system clocks between consecutive frames.
- R9: For a read of an address from 0x40 to 0x5F, the gap before the follow-up frame is at least BUF_GAP_CYCLES. All other follow-up gaps use the shorter spacing, which is below BUF_GAP_CYCLES.
- R10: cmd_ready is low from acceptance until completion. A cmd_start raised while cmd_ready is low is ignored, and no frame is sent while cmd_ready is high.
- R11: res_done is a one-cycle pulse, one per command. res_rdata, res_error and res_retries stay unchanged from completion until the next command is accepted.
- R12: After reset, chip select is high, SCLK is low, cmd_ready = 1, and res_done, res_error, res_retries and res_rdata are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Accept a command when cmd_ready is high |
| cmd_write | input | 1 | 1 = register write, 0 = register read |
| cmd_addr | input | 7 | Register address |
| cmd_wdata | input | 8 | Write data |
| cmd_ready | output | 1 | Idle, can accept a command |
| res_done | output | 1 | One-cycle completion pulse |
| res_rdata | output | 8 | Data byte of the accepted reply |
| res_error | output | 1 | Retry limit exhausted (sticky until next command) |
| res_retries | output | RETRY_W | Retries used by the last command |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Controller data out |
| spi_miso | input | 1 | Target data in |

## Verification
The result registers and the res_done pulse are updated one system clock after chip select rises at the end of the follow-up frame that settles the command. The bench therefore polls res_done at every falling clock edge and reads the result ports in that same half-cycle. The target model in the bench records each frame, its SCLK edge count and the preceding chip-select-high gap at the chip-select edges. These records are compared only after res_done, against frame counts and contents worked out from the fault pattern that was injected. Ten cycles after completion the results are sampled again to confirm they hold, and the number of res_done pulses is checked to be one.

// File: rtl/spi_retry_pkg.sv
package spi_retry_pkg;

    typedef enum logic [2:0] {
        RSP_VALID,
        RSP_NOCLK,
        RSP_TGT_CRC,
        RSP_NOT_READY,
        RSP_MISMATCH
    } rsp_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD_GO,
        ST_CMD_WAIT,
        ST_GAP_POLL,
        ST_POLL_GO,
        ST_POLL_WAIT,
        ST_GAP_RETRY
    } ctl_state_e;

    typedef struct packed {
        logic       wr;
        logic [6:0] addr;
        logic [7:0] data;
    } spi_cmd_t;

    localparam logic [7:0] CRC_POLY       = 8'h07;
    localparam logic [7:0] TAIL_NOCLK     = 8'hFF;
    localparam logic [7:0] TAIL_TGT_CRC   = 8'hAA;
    localparam logic [7:0] TAIL_NOT_READY = 8'h00;
    localparam logic [6:0] BUF_LO         = 7'h40;
    localparam logic [6:0] BUF_HI         = 7'h5F;

    // Bit-serial CRC-8 over two bytes, MSB first, zero start value
    function automatic logic [7:0] crc8_pair(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] msg;
        logic [7:0]  c;
        msg = {a, b};
        c   = 8'h00;
        for (int i = 15; i >= 0; i--) begin
            if (c[7] ^ msg[i]) c = {c[6:0], 1'b0} ^ CRC_POLY;
            else               c = {c[6:0], 1'b0};
        end
        return c;
    endfunction

    function automatic logic [23:0] build_frame(input spi_cmd_t c);
        logic [7:0] hdr;
        hdr = {c.wr, c.addr};
        return {hdr, c.data, crc8_pair(hdr, c.data)};
    endfunction

    function automatic logic in_buffer_window(input logic [6:0] a);
        return (a >= BUF_LO) && (a <= BUF_HI);
    endfunction

endpackage

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
    parameter int WIDTH    = 24,
    parameter int HALF_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] tx,
    output logic             done,
    output logic [WIDTH-1:0] rx,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BIT_W = $clog2(WIDTH + 1);

    logic             active;
    logic [DIV_W-1:0] div_cnt;
    logic [BIT_W-1:0] bit_cnt;
    logic [WIDTH-1:0] tx_sh;
    logic [WIDTH-1:0] rx_sh;
    logic             half_tick;

    assign half_tick = (div_cnt == DIV_W'(HALF_DIV - 1));
    assign mosi      = active & tx_sh[WIDTH-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            cs_n    <= 1'b1;
            sclk    <= 1'b0;
            done    <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            rx      <= '0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active  <= 1'b1;
                    cs_n    <= 1'b0;
                    sclk    <= 1'b0;
                    tx_sh   <= tx;
                    div_cnt <= '0;
                    bit_cnt <= '0;
                end
            end else if (!half_tick) begin
                div_cnt <= div_cnt + 1'b1;
            end else begin
                div_cnt <= '0;
                if (!sclk) begin
                    sclk  <= 1'b1;
                    rx_sh <= {rx_sh[WIDTH-2:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bit_cnt == BIT_W'(WIDTH - 1)) begin
                        active <= 1'b0;
                        cs_n   <= 1'b1;
                        done   <= 1'b1;
                        rx     <= rx_sh;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        tx_sh   <= {tx_sh[WIDTH-2:0], 1'b0};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_gap_timer.sv
module spi_gap_timer #(
    parameter int MAX_LEN = 25000,
    localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= len;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/spi_reply_check.sv
module spi_reply_check
    import spi_retry_pkg::*;
(
    input  logic [23:0] rx,
    input  logic [7:0]  exp_hdr,
    output rsp_kind_e   kind,
    output logic [7:0]  data
);
    logic [7:0] b0, b1, b2;
    logic       lead_ones;

    assign b0        = rx[23:16];
    assign b1        = rx[15:8];
    assign b2        = rx[7:0];
    assign lead_ones = (b0 == 8'hFF) && (b1 == 8'hFF);
    assign data      = b1;

    always_comb begin
        if (lead_ones && b2 == TAIL_NOCLK)                     kind = RSP_NOCLK;
        else if (lead_ones && b2 == TAIL_TGT_CRC)              kind = RSP_TGT_CRC;
        else if (lead_ones && b2 == TAIL_NOT_READY)            kind = RSP_NOT_READY;
        else if (b0 != exp_hdr || b2 != crc8_pair(b0, b1))     kind = RSP_MISMATCH;
        else                                                   kind = RSP_VALID;
    end
endmodule

// File: rtl/spi_retry_host.sv
module spi_retry_host
    import spi_retry_pkg::*;
#(
    parameter int CLK_HALF_DIV   = 4,
    parameter int GAP_CYCLES     = 6250,
    parameter int BUF_GAP_CYCLES = 25000,
    parameter int MAX_RETRY      = 3,
    parameter int RETRY_W        = 4,
    parameter bit CRC_ON         = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_start,
    input  logic               cmd_write,
    input  logic [6:0]         cmd_addr,
    input  logic [7:0]         cmd_wdata,
    output logic               cmd_ready,
    output logic               res_done,
    output logic [7:0]         res_rdata,
    output logic               res_error,
    output logic [RETRY_W-1:0] res_retries,
    output logic               spi_sclk,
    output logic               spi_cs_n,
    output logic               spi_mosi,
    input  logic               spi_miso
);
    localparam int FRAME_BITS = CRC_ON ? 24 : 16;
    localparam int LONG_GAP   = (BUF_GAP_CYCLES > GAP_CYCLES) ? BUF_GAP_CYCLES : GAP_CYCLES;
    localparam int GAP_W      = $clog2(LONG_GAP + 1);

    ctl_state_e             state;
    spi_cmd_t               cur;
    spi_cmd_t               poll_cmd;
    logic [RETRY_W-1:0]     tries;
    logic [23:0]            tx_full;
    logic [23:0]            rx24;
    logic [FRAME_BITS-1:0]  eng_tx;
    logic [FRAME_BITS-1:0]  eng_rx;
    logic                   eng_start;
    logic                   eng_done;
    logic                   timer_load;
    logic [GAP_W-1:0]       timer_len;
    logic [GAP_W-1:0]       poll_gap;
    logic                   gap_over;
    rsp_kind_e              rsp_kind;
    logic [7:0]             rsp_data;
    logic                   at_limit;

    always_comb begin
        poll_cmd      = cur;
        poll_cmd.wr   = 1'b0;
        poll_cmd.data = 8'h00;
    end

    assign tx_full   = (state == ST_POLL_GO) ? build_frame(poll_cmd) : build_frame(cur);
    assign eng_tx    = tx_full[23 -: FRAME_BITS];
    assign eng_start = (state == ST_CMD_GO) || (state == ST_POLL_GO);
    assign cmd_ready = (state == ST_IDLE);
    assign at_limit  = (tries == RETRY_W'(MAX_RETRY));

    generate
        if (CRC_ON) begin : g_crc_frame
            assign rx24 = eng_rx;
        end else begin : g_plain_frame
            assign rx24 = {eng_rx, crc8_pair(eng_rx[FRAME_BITS-1 -: 8], eng_rx[7:0])};
        end
    endgenerate

    assign poll_gap   = (!cur.wr && in_buffer_window(cur.addr)) ? GAP_W'(BUF_GAP_CYCLES)
                                                                : GAP_W'(GAP_CYCLES);
    assign timer_len  = (state == ST_CMD_WAIT) ? poll_gap : GAP_W'(GAP_CYCLES);
    assign timer_load = eng_done &&
                        ((state == ST_CMD_WAIT) ||
                         (state == ST_POLL_WAIT && rsp_kind != RSP_VALID && !at_limit));

    spi_frame_shifter #(
        .WIDTH    (FRAME_BITS),
        .HALF_DIV (CLK_HALF_DIV)
    ) u_shift (
        .clk   (clk),
        .rst   (rst),
        .start (eng_start),
        .tx    (eng_tx),
        .done  (eng_done),
        .rx    (eng_rx),
        .sclk  (spi_sclk),
        .cs_n  (spi_cs_n),
        .mosi  (spi_mosi),
        .miso  (spi_miso)
    );

    spi_gap_timer #(
        .MAX_LEN (LONG_GAP)
    ) u_gap (
        .clk     (clk),
        .rst     (rst),
        .load    (timer_load),
        .len     (timer_len),
        .expired (gap_over)
    );

    spi_reply_check u_chk_rx (
        .rx      (rx24),
        .exp_hdr ({cur.wr, cur.addr}),
        .kind    (rsp_kind),
        .data    (rsp_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cur         <= '0;
            tries       <= '0;
            res_done    <= 1'b0;
            res_rdata   <= 8'h00;
            res_error   <= 1'b0;
            res_retries <= '0;
        end else begin
            res_done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cmd_start) begin
                        cur         <= '{wr: cmd_write, addr: cmd_addr, data: cmd_wdata};
                        tries       <= '0;
                        res_error   <= 1'b0;
                        res_retries <= '0;
                        state       <= ST_CMD_GO;
                    end
                end
                ST_CMD_GO:    state <= ST_CMD_WAIT;
                ST_CMD_WAIT:  if (eng_done) state <= ST_GAP_POLL;
                ST_GAP_POLL:  if (gap_over) state <= ST_POLL_GO;
                ST_POLL_GO:   state <= ST_POLL_WAIT;
                ST_POLL_WAIT: begin
                    if (eng_done) begin
                        if (rsp_kind == RSP_VALID) begin
                            res_done    <= 1'b1;
                            res_rdata   <= rsp_data;
                            res_retries <= tries;
                            state       <= ST_IDLE;
                        end else if (at_limit) begin
                            res_done    <= 1'b1;
                            res_error   <= 1'b1;
                            res_retries <= tries;
                            state       <= ST_IDLE;
                        end else begin
                            tries <= tries + 1'b1;
                            state <= ST_GAP_RETRY;
                        end
                    end
                end
                ST_GAP_RETRY: if (gap_over) state <= ST_CMD_GO;
                default:      state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_retry_host_chk.sv
module spi_retry_host_chk #(
    parameter int MAX_RETRY = 3,
    parameter int RETRY_W   = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               cmd_start,
    input logic               cmd_ready,
    input logic               res_done,
    input logic [7:0]         res_rdata,
    input logic               res_error,
    input logic [RETRY_W-1:0] res_retries,
    input logic               spi_sclk,
    input logic               spi_cs_n
);
    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);  // R2

    AST_IDLE_NO_FRAME: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> spi_cs_n);  // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        res_done |=> !res_done);  // R11

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        res_done |-> cmd_ready);  // R11

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd_ready && !cmd_start) |=>
            ($stable(res_rdata) && $stable(res_error) && $stable(res_retries)));  // R11

    AST_RETRY_CAP: assert property (@(posedge clk) disable iff (rst)
        res_retries <= RETRY_W'(MAX_RETRY));  // R7

    AST_ERROR_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (res_done && res_error) |-> (res_retries == RETRY_W'(MAX_RETRY)));  // R7
endmodule

bind spi_retry_host spi_retry_host_chk #(
    .MAX_RETRY (MAX_RETRY),
    .RETRY_W   (RETRY_W)
) u_host_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_start   (cmd_start),
    .cmd_ready   (cmd_ready),
    .res_done    (res_done),
    .res_rdata   (res_rdata),
    .res_error   (res_error),
    .res_retries (res_retries),
    .spi_sclk    (spi_sclk),
    .spi_cs_n    (spi_cs_n)
);

// File: tb/spi_retry_host_tb.sv
module spi_retry_host_tb;
    localparam int HALF   = 2;
    localparam int GAP    = 20;
    localparam int BUFGAP = 60;
    localparam int MAXR   = 3;
    localparam int RW     = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_start = 1'b0;
    logic          cmd_write = 1'b0;
    logic [6:0]    cmd_addr  = '0;
    logic [7:0]    cmd_wdata = '0;
    logic          cmd_ready, res_done, res_error;
    logic [7:0]    res_rdata;
    logic [RW-1:0] res_retries;
    logic          spi_sclk, spi_cs_n, spi_mosi, spi_miso;

    always #4 clk = ~clk;

    spi_retry_host #(
        .CLK_HALF_DIV   (HALF),
        .GAP_CYCLES     (GAP),
        .BUF_GAP_CYCLES (BUFGAP),
        .MAX_RETRY      (MAXR),
        .RETRY_W        (RW),
        .CRC_ON         (1'b1)
    ) u_dut (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
        .res_done(res_done), .res_rdata(res_rdata), .res_error(res_error),
        .res_retries(res_retries), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit over     = 0;

    function automatic logic [7:0] tb_crc(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] c;
        c = 8'h00;
        c ^= a;
        for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        c ^= b;
        for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        return c;
    endfunction

    function automatic logic [23:0] exp_frame(input logic w, input logic [6:0] a, input logic [7:0] d);
        return {w, a, d, tb_crc({w, a}, d)};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- target model ----------------
    logic [7:0]  tmem   [128];
    logic [7:0]  shadow [128];
    logic [23:0] out_sh = '0;
    logic [23:0] in_sh  = '0;
    logic [23:0] prev_frame = '0;
    logic [23:0] frames [16];
    int          gaps   [16];
    int          fault_code [16];
    int          txn_idx  = 0;
    int          rise_cnt = 0;
    int          bad_bits = 0;
    int          last_rise = 0;
    int          done_cnt = 0;
    bit          armed = 0;

    assign spi_miso = spi_cs_n ? 1'b1 : out_sh[23];

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000 && !over) begin
            over = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R3: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    always @(negedge clk) if (res_done) done_cnt++;

    always @(negedge spi_cs_n) begin
        if (armed) begin
            logic [7:0]  hdr, dat, h2;
            logic [23:0] good;
            int          f;
            hdr  = prev_frame[23:16];
            dat  = hdr[7] ? prev_frame[15:8] : tmem[hdr[6:0]];
            good = {hdr, dat, tb_crc(hdr, dat)};
            f    = (txn_idx < 16) ? fault_code[txn_idx] : 0;
            h2   = hdr ^ 8'h01;
            case (f)
                1:       out_sh = 24'hFFFFFF;
                2:       out_sh = 24'hFFFFAA;
                3:       out_sh = 24'hFFFF00;
                4:       out_sh = good ^ 24'h000001;
                5:       out_sh = {h2, dat, tb_crc(h2, dat)};
                default: out_sh = good;
            endcase
            if (txn_idx < 16) gaps[txn_idx] = cyc - last_rise;
            rise_cnt = 0;
        end
    end

    always @(posedge spi_sclk) if (!spi_cs_n) begin
        in_sh = {in_sh[22:0], spi_mosi};
        rise_cnt++;
    end

    always @(negedge spi_sclk) if (!spi_cs_n) out_sh = {out_sh[22:0], 1'b0};

    always @(posedge spi_cs_n) begin
        if (armed) begin
            if (txn_idx < 16) frames[txn_idx] = in_sh;
            if (in_sh[23] && tb_crc(in_sh[23:16], in_sh[15:8]) == in_sh[7:0])
                tmem[in_sh[22:16]] = in_sh[15:8];
            if (rise_cnt != 24) bad_bits++;
            prev_frame = in_sh;
            last_rise  = cyc;
            txn_idx++;
        end
    end

    // ---------------- command driver ----------------
    task automatic clear_faults();
        for (int i = 0; i < 16; i++) fault_code[i] = 0;
    endtask

    task automatic do_cmd(input logic w, input logic [6:0] a, input logic [7:0] d, input bit poke);
        int k, exp_txn, exp_ret, waited, dc0;
        logic exp_err;
        logic [7:0] exp_data;
        bit fr_ok, g8_ok, g9_ok, buf_rd;
        logic [7:0] r_snap, t_snap;
        logic e_snap;

        k = 0;
        while (k <= MAXR && fault_code[2*k+1] != 0) k++;
        if (k > MAXR) begin exp_err = 1; exp_ret = MAXR; exp_txn = 2*(MAXR+1); end
        else          begin exp_err = 0; exp_ret = k;    exp_txn = 2*(k+1);    end
        exp_data = w ? d : shadow[a];
        buf_rd   = !w && (a >= 7'h40) && (a <= 7'h5F);

        txn_idx  = 0;
        bad_bits = 0;
        dc0      = done_cnt;
        @(negedge clk);
        cmd_start = 1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_start = 0;
        if (poke) begin
            repeat (3) @(negedge clk);
            check(cmd_ready == 1'b0, "R10", "cmd_ready while busy", cmd_ready, 0);
            cmd_start = 1; cmd_write = ~w; cmd_addr = a ^ 7'h01; cmd_wdata = ~d;
            @(negedge clk);
            cmd_start = 0;
        end
        waited = 0;
        while (!res_done && waited < 20000) begin @(negedge clk); waited++; end
        check(res_done == 1'b1, "R3", "completion seen", res_done, 1);
        check(res_error == exp_err, exp_err ? "R7" : "R5", "res_error", res_error, exp_err);
        check(res_retries == RW'(exp_ret), exp_ret > 0 ? "R5" : "R4", "res_retries", res_retries, exp_ret);
        if (!exp_err) check(res_rdata == exp_data, "R4", "res_rdata", res_rdata, exp_data);
        check(txn_idx == exp_txn, "R3", "frame count", txn_idx, exp_txn);
        fr_ok = 1;
        for (int j = 0; j < txn_idx && j < 16; j++) begin
            if ((j % 2) == 0 && frames[j] != exp_frame(w, a, d))       fr_ok = 0;
            if ((j % 2) == 1 && frames[j] != exp_frame(1'b0, a, 8'h00)) fr_ok = 0;
        end
        check(fr_ok, "R1", "frame contents", frames[0], exp_frame(w, a, d));
        check(bad_bits == 0, "R2", "sclk edges per frame", bad_bits, 0);
        g8_ok = 1; g9_ok = 1;
        for (int j = 1; j < txn_idx && j < 16; j++) begin
            if (gaps[j] < GAP) g8_ok = 0;
            if ((j % 2) == 1 && buf_rd && gaps[j] < BUFGAP) g9_ok = 0;
            if ((j % 2) == 1 && !buf_rd && gaps[j] >= BUFGAP) g9_ok = 0;
        end
        check(g8_ok, "R8", "min spacing", gaps[1], GAP);
        check(g9_ok, "R9", "follow-up spacing", gaps[1], buf_rd ? BUFGAP : GAP);
        if (w) shadow[a] = d;
        r_snap = res_rdata; t_snap = res_retries; e_snap = res_error;
        repeat (10) @(negedge clk);
        check(res_rdata == r_snap && res_retries == t_snap && res_error == e_snap,
              "R11", "results held", res_rdata, r_snap);
        check(done_cnt - dc0 == 1, "R11", "done pulses", done_cnt - dc0, 1);
        clear_faults();
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 128; i++) begin
            tmem[i]   = 8'(i * 7 + 3);
            shadow[i] = 8'(i * 7 + 3);
        end
        for (int i = 0; i < 16; i++) begin frames[i] = '0; gaps[i] = 0; end
        clear_faults();
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(spi_cs_n == 1 && spi_sclk == 0, "R12", "bus idle after reset", {spi_cs_n, spi_sclk}, 2);
        check(cmd_ready == 1 && res_done == 0, "R12", "ready after reset", {cmd_ready, res_done}, 2);
        check(res_error == 0 && res_retries == 0 && res_rdata == 0, "R12", "results after reset",
              res_rdata, 0);
        armed = 1;

        do_cmd(1'b1, 7'h12, 8'hA5, 0);                        // R1 R4 write
        do_cmd(1'b0, 7'h12, 8'h00, 0);                        // R4 read back
        fault_code[1] = 1; do_cmd(1'b0, 7'h12, 8'h00, 0);     // R5 clock off
        fault_code[1] = 2; fault_code[3] = 2;
        do_cmd(1'b1, 7'h33, 8'h5C, 0);                        // R5 target CRC error
        fault_code[1] = 3; do_cmd(1'b0, 7'h33, 8'h00, 0);     // R5 not ready
        fault_code[1] = 4; do_cmd(1'b0, 7'h05, 8'h00, 0);     // R6 bad CRC
        fault_code[1] = 5; do_cmd(1'b1, 7'h7F, 8'hFF, 0);     // R6 bad echo
        for (int i = 1; i < 8; i += 2) fault_code[i] = 1 + (i % 3);
        do_cmd(1'b0, 7'h20, 8'h00, 0);                        // R7 limit
        do_cmd(1'b0, 7'h21, 8'h00, 0);                        // R7 error cleared
        fault_code[0] = 1; do_cmd(1'b0, 7'h22, 8'h00, 0);     // R3 first reply ignored
        do_cmd(1'b0, 7'h40, 8'h00, 0);                        // R9 low edge
        do_cmd(1'b0, 7'h5F, 8'h00, 0);                        // R9 high edge
        do_cmd(1'b0, 7'h60, 8'h00, 0);                        // R9 outside
        do_cmd(1'b1, 7'h45, 8'h11, 0);                        // R9 write uses short gap
        do_cmd(1'b1, 7'h0A, 8'h3C, 1);                        // R10 start while busy

        for (int n = 0; n < 30; n++) begin
            logic       w;
            logic [6:0] a;
            logic [7:0] d;
            w = 1'($urandom % 2);
            a = 7'($urandom % 128);
            d = 8'($urandom);
            for (int i = 0; i < 8; i++)
                fault_code[i] = (($urandom % 4) == 0) ? int'(1 + ($urandom % 5)) : 0;
            do_cmd(w, a, w ? d : 8'h00, 0);
        end

        if (!over) begin
            over = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule